// File: doc/BRIEF.md
# Bitstream Header Ratio Selector

This block sits in series with a 32-bit configuration word stream that uses a valid/ready handshake. Words pass from input to output unchanged. As they pass, the block counts them and picks two indicator fields out of fixed header positions: an encryption field and a compression flag. From those two indications and a configuration-width select, it produces the 2-bit clock-to-data ratio code that the downstream configuration engine needs for the rest of the stream.

A stream that ends before the compression word arrives cannot be classified. For such a stream the block raises a one-cycle header-error pulse and never declares the ratio valid. Before user mode is entered, a controller can raise a padding request. While it is high, the block stalls the input, drives all-ones sync words downstream and forces the ratio to x1. When the request drops, the ratio captured from the header is shown again.

Top module: `hdr_ratio_sel`

## Requirements
- R1: After reset, `ratio_valid`, `hdr_err` and `ratio_code` are all 0.
- R2: While `pad_active` is low, `m_data`, `m_valid` and `m_last` equal `s_data`, `s_valid` and `s_last`, and `s_ready` equals `m_ready`, with no added cycle.
- R3: Word positions count from 0. Position 0 is the first word accepted after reset or after a word accepted with `s_last` high. At position 69, a nonzero value in bits [3:2] marks the stream as encrypted.
- R4: At position 229, bit 1 carries the compression flag with inverted sense: a 0 there marks the stream as compressed.
- R5: The ratio code values are 0 = x1, 1 = x2, 2 = x4 and 3 = x8. A plain stream gives 0. An encrypted-only stream gives 1 when `wide_sel` = 0 (16-bit) and 2 when `wide_sel` = 1 (32-bit). A compressed stream, whether encrypted or not, gives 2 when `wide_sel` = 0 and 3 when `wide_sel` = 1.
- R6: `ratio_valid` goes high in the cycle after the position-229 word is accepted. It stays high until the position-0 word of the next stream is accepted. While `ratio_valid` is low, `ratio_code` is 0.
- R7: If a word with `s_last` high is accepted at a position below 229, `hdr_err` is high for exactly the next cycle and `ratio_valid` stays low.
- R8: Words at positions other than 69 and 229 have no effect on the ratio. This includes words beyond position 229, where the word counter saturates.
- R9: While `pad_active` is high: `ratio_code` is 0, `m_data` is all ones, `m_valid` is 1, `m_last` is 0, `s_ready` is 0, and no input word is accepted.
- R10: When `pad_active` drops, the captured code reappears in the same cycle. `wide_sel` acts on `ratio_code` without any register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Input word ready |
| s_data | input | 32 | Input configuration word |
| s_last | input | 1 | Input word is the last of its stream |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | 32 | Output word (input word, or all ones while padding) |
| m_last | output | 1 | Output word is the last of its stream |
| wide_sel | input | 1 | 1 = 32-bit configuration width, 0 = 16-bit |
| pad_active | input | 1 | Padding phase: stall the input, emit sync words, force x1 |
| ratio_code | output | 2 | Clock-to-data ratio code |
| ratio_valid | output | 1 | Header classified, code meaningful |
| hdr_err | output | 1 | One-cycle pulse: stream ended before the compression word |

## Verification
The pass-through path, the padding override and the width select are combinational. The bench checks them 1 ns after driving the inputs on the falling edge, within the same cycle. `ratio_valid` and `hdr_err` are each one register behind the accepting rising edge. The bench therefore checks them on the falling edge that follows that edge, and checks again one cycle later to confirm that the error pulse has ended. The in-stream checks at positions 1, 229 and 230 pin the rise of `ratio_valid` to the exact cycle: it is low while word 229 is presented and high once word 230 is presented.

// File: rtl/hdr_ratio_pkg.sv
package hdr_ratio_pkg;

   typedef enum logic [1:0] {
      RATIO_X1 = 2'd0,
      RATIO_X2 = 2'd1,
      RATIO_X4 = 2'd2,
      RATIO_X8 = 2'd3
   } ratio_e;

   // Base code from the header indications; a 32-bit width steps it up once
   // for any stream that is not plain.
   function automatic ratio_e ratio_from_hdr(input logic enc,
                                             input logic cmp,
                                             input logic wide);
      logic [1:0] base;
      if (!enc && !cmp) begin
         return RATIO_X1;
      end
      base = cmp ? 2'd2 : 2'd1;
      return ratio_e'(base + {1'b0, wide});
   endfunction

endpackage

// File: rtl/hdr_word_counter.sv
module hdr_word_counter #(
   parameter int unsigned MAX_COUNT = 230,
   parameter int unsigned CNT_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc,
   input  logic             last,
   output logic [CNT_W-1:0] idx
);

   localparam logic [CNT_W-1:0] TOP_C = CNT_W'(MAX_COUNT);

   if (CNT_W < $clog2(MAX_COUNT + 1)) begin : g_width_chk
      $error("hdr_word_counter: CNT_W too narrow for MAX_COUNT");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= '0;
      end else if (acc) begin
         if (last) begin
            idx <= '0;
         end else if (idx != TOP_C) begin
            idx <= idx + 1'b1;
         end
      end
   end

   // R8: the position never runs past the saturation value
   a_r8_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= TOP_C);

   // R3: an accepted last word restarts the position at zero
   a_r3_restart_at_last: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && last) |=> (idx == '0));

   // R9: without an accepted word the position holds
   a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> $stable(idx));

endmodule

// File: rtl/hdr_field_capture.sv
module hdr_field_capture #(
   parameter int unsigned CNT_W   = 8,
   parameter int unsigned ENC_IDX = 69,
   parameter int unsigned CMP_IDX = 229,
   parameter int unsigned ENC_W   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc,
   input  logic             last,
   input  logic [CNT_W-1:0] idx,
   input  logic [ENC_W-1:0] enc_field,
   input  logic             cmp_bit,
   output logic             is_enc,
   output logic             is_cmp,
   output logic             hdr_ok,
   output logic             hdr_err
);

   localparam logic [CNT_W-1:0] ENC_AT = CNT_W'(ENC_IDX);
   localparam logic [CNT_W-1:0] CMP_AT = CNT_W'(CMP_IDX);

   logic first_word;
   assign first_word = acc && (idx == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         is_enc  <= 1'b0;
         is_cmp  <= 1'b0;
         hdr_ok  <= 1'b0;
         hdr_err <= 1'b0;
      end else begin
         hdr_err <= acc && last && (idx < CMP_AT);
         if (first_word) begin
            is_enc <= 1'b0;
            is_cmp <= 1'b0;
            hdr_ok <= 1'b0;
         end
         if (acc && (idx == ENC_AT)) begin
            is_enc <= |enc_field;
         end
         if (acc && (idx == CMP_AT)) begin
            is_cmp <= ~cmp_bit;
            hdr_ok <= 1'b1;
         end
      end
   end

   // R6: the classification is due one cycle after the compression word
   a_r6_ok_after_cmp: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && (idx == CMP_AT)) |=> hdr_ok);

   // R6: once set, valid holds until the next stream's first word
   a_r6_ok_held: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_ok && !first_word) |=> hdr_ok);

   // R7: an error pulse never coexists with a valid ratio
   a_r7_err_excludes_ok: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_err |-> !hdr_ok);

   // R3: a nonzero encryption field is remembered
   a_r3_enc_seen: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && (idx == ENC_AT) && (|enc_field)) |=> is_enc);

endmodule

// File: rtl/ratio_encoder.sv
module ratio_encoder
   import hdr_ratio_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       is_enc,
   input  logic       is_cmp,
   input  logic       hdr_ok,
   input  logic       wide_sel,
   input  logic       pad_active,
   output logic [1:0] ratio_code
);

   ratio_e hdr_code;

   always_comb begin
      hdr_code = ratio_from_hdr(is_enc, is_cmp, wide_sel);
      if (pad_active || !hdr_ok) begin
         ratio_code = RATIO_X1;
      end else begin
         ratio_code = hdr_code;
      end
   end

   // R5: a 16-bit width never reaches x8
   a_r5_narrow_caps_x4: assert property (@(posedge clk) disable iff (!rst_n)
      !wide_sel |-> (ratio_code != RATIO_X8));

   // R5: a plain header always yields x1
   a_r5_plain_x1: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_enc && !is_cmp) |-> (ratio_code == RATIO_X1));

   // R5: a 32-bit encrypted or compressed stream is never below x4
   a_r5_wide_min_x4: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_ok && !pad_active && wide_sel && (is_enc || is_cmp))
         |-> (ratio_code >= RATIO_X4));

endmodule

// File: rtl/hdr_ratio_sel.sv
module hdr_ratio_sel
   import hdr_ratio_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned MIN_WORDS = 230,
   parameter int unsigned ENC_IDX   = 69,
   parameter int unsigned ENC_LSB   = 2,
   parameter int unsigned ENC_W     = 2,
   parameter int unsigned CMP_IDX   = 229,
   parameter int unsigned CMP_BIT   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_valid,
   output logic              s_ready,
   input  logic [DATA_W-1:0] s_data,
   input  logic              s_last,
   output logic              m_valid,
   input  logic              m_ready,
   output logic [DATA_W-1:0] m_data,
   output logic              m_last,
   input  logic              wide_sel,
   input  logic              pad_active,
   output logic [1:0]        ratio_code,
   output logic              ratio_valid,
   output logic              hdr_err
);

   localparam int unsigned CNT_W = $clog2(MIN_WORDS + 1);

   if (ENC_IDX == 0 || CMP_IDX == 0) begin : g_pos_zero_chk
      $error("hdr_ratio_sel: indicator words must not sit at position 0");
   end
   if (ENC_IDX >= MIN_WORDS || CMP_IDX >= MIN_WORDS) begin : g_pos_range_chk
      $error("hdr_ratio_sel: indicator words must lie below MIN_WORDS");
   end
   if (ENC_IDX == CMP_IDX) begin : g_pos_clash_chk
      $error("hdr_ratio_sel: indicator positions must differ");
   end
   if (ENC_LSB + ENC_W > DATA_W || CMP_BIT >= DATA_W) begin : g_bit_chk
      $error("hdr_ratio_sel: indicator bits outside the word");
   end

   logic             acc;
   logic [CNT_W-1:0] idx;
   logic             is_enc;
   logic             is_cmp;

   assign s_ready = pad_active ? 1'b0 : m_ready;
   assign acc     = s_valid && s_ready;
   assign m_valid = pad_active ? 1'b1 : s_valid;
   assign m_data  = pad_active ? {DATA_W{1'b1}} : s_data;
   assign m_last  = pad_active ? 1'b0 : s_last;

   hdr_word_counter #(
      .MAX_COUNT (MIN_WORDS),
      .CNT_W     (CNT_W)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .acc   (acc),
      .last  (s_last),
      .idx   (idx)
   );

   hdr_field_capture #(
      .CNT_W   (CNT_W),
      .ENC_IDX (ENC_IDX),
      .CMP_IDX (CMP_IDX),
      .ENC_W   (ENC_W)
   ) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc       (acc),
      .last      (s_last),
      .idx       (idx),
      .enc_field (s_data[ENC_LSB +: ENC_W]),
      .cmp_bit   (s_data[CMP_BIT]),
      .is_enc    (is_enc),
      .is_cmp    (is_cmp),
      .hdr_ok    (ratio_valid),
      .hdr_err   (hdr_err)
   );

   ratio_encoder u_enc (
      .clk        (clk),
      .rst_n      (rst_n),
      .is_enc     (is_enc),
      .is_cmp     (is_cmp),
      .hdr_ok     (ratio_valid),
      .wide_sel   (wide_sel),
      .pad_active (pad_active),
      .ratio_code (ratio_code)
   );

   // R9: padding stalls the input and presents a non-final sync word
   a_r9_pad_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      pad_active |-> (!s_ready && m_valid && !m_last && (ratio_code == RATIO_X1)));

   // R9: padding never disturbs a classified header
   a_r9_pad_keeps_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_active && ratio_valid) |=> ratio_valid);

endmodule

// File: tb/sim_hdr_ratio_sel.sv
module sim_hdr_ratio_sel;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        s_valid = 1'b0;
   logic        s_ready;
   logic [31:0] s_data = '0;
   logic        s_last = 1'b0;
   logic        m_valid;
   logic        m_ready = 1'b1;
   logic [31:0] m_data;
   logic        m_last;
   logic        wide_sel = 1'b1;
   logic        pad_active = 1'b0;
   logic [1:0]  ratio_code;
   logic        ratio_valid;
   logic        hdr_err;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   hdr_ratio_sel u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .s_valid     (s_valid),
      .s_ready     (s_ready),
      .s_data      (s_data),
      .s_last      (s_last),
      .m_valid     (m_valid),
      .m_ready     (m_ready),
      .m_data      (m_data),
      .m_last      (m_last),
      .wide_sel    (wide_sel),
      .pad_active  (pad_active),
      .ratio_code  (ratio_code),
      .ratio_valid (ratio_valid),
      .hdr_err     (hdr_err)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // Code expected from the R5 table
   function automatic logic [1:0] exp_code(input logic [1:0] enc, input logic cmpb,
                                           input logic wide);
      logic e;
      logic c;
      e = |enc;
      c = !cmpb;
      if (!e && !c) return 2'd0;
      return (c ? 2'd2 : 2'd1) + {1'b0, wide};
   endfunction

   // Filler words carry bits [3:2]=11 and bit 1=0 so a misplaced capture shows
   function automatic logic [31:0] word_at(input int i, input logic [1:0] enc,
                                           input logic cmpb);
      logic [31:0] w;
      w = 32'hA500_000C | (32'(i) << 8);
      if (i == 69) w = (w & ~32'h0000_000C) | {28'd0, enc, 2'b00};
      if (i == 229) w = (w & ~32'h0000_0002) | {30'd0, cmpb, 1'b0};
      return w;
   endfunction

   task automatic run_stream(input int n, input logic [1:0] enc, input logic cmpb);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         s_valid = 1'b1;
         s_data  = word_at(i, enc, cmpb);
         s_last  = (i == n - 1);
         #1;
         if (i == 0 || i == 69 || i == n - 1) begin
            check("R2 m_data", m_data, s_data);
            check("R2 m_valid/m_last/s_ready", {29'd0, m_valid, m_last, s_ready},
                  {29'd0, 1'b1, s_last, 1'b1});
         end
         if (i == 1) check("R6 cleared by new stream", {31'd0, ratio_valid}, 32'd0);
         if (i == 229) check("R6 not yet valid", {31'd0, ratio_valid}, 32'd0);
         if (i == 230) check("R6 valid next cycle", {31'd0, ratio_valid}, 32'd1);
      end
      @(negedge clk);
      s_valid = 1'b0;
      s_last  = 1'b0;
      #1;
   endtask

   task automatic t_reset;
      check("R1 reset outputs", {28'd0, ratio_code, ratio_valid, hdr_err}, 32'd0);
   endtask

   task automatic t_classify(input logic [1:0] enc, input logic cmpb, input string tag);
      wide_sel = 1'b1;
      run_stream(230, enc, cmpb);
      check({"R3 R4 R6 valid ", tag}, {31'd0, ratio_valid}, 32'd1);
      check({"R5 code wide ", tag}, {30'd0, ratio_code}, {30'd0, exp_code(enc, cmpb, 1'b1)});
      check({"R7 no error ", tag}, {31'd0, hdr_err}, 32'd0);
      wide_sel = 1'b0;
      #1;
      check({"R10 R5 code narrow ", tag}, {30'd0, ratio_code},
            {30'd0, exp_code(enc, cmpb, 1'b0)});
      wide_sel = 1'b1;
      #1;
   endtask

   task automatic t_long_stream;
      wide_sel = 1'b1;
      run_stream(300, 2'b00, 1'b1);
      check("R8 later words ignored", {30'd0, ratio_code}, 32'd0);
      check("R8 valid after long stream", {31'd0, ratio_valid}, 32'd1);
   endtask

   task automatic t_short_stream;
      run_stream(229, 2'b11, 1'b0);
      check("R7 error pulse", {31'd0, hdr_err}, 32'd1);
      check("R7 valid low", {31'd0, ratio_valid}, 32'd0);
      check("R6 code zero when invalid", {30'd0, ratio_code}, 32'd0);
      @(negedge clk);
      #1;
      check("R7 pulse one cycle", {31'd0, hdr_err}, 32'd0);
   endtask

   task automatic t_pad;
      wide_sel = 1'b1;
      run_stream(230, 2'b01, 1'b0);
      check("R9 pre-pad code", {30'd0, ratio_code}, 32'd3);
      @(negedge clk);
      pad_active = 1'b1;
      s_valid = 1'b1;
      s_data  = 32'h1234_5678;
      s_last  = 1'b1;
      for (int k = 0; k < 3; k++) begin
         #1;
         check("R9 pad code x1", {30'd0, ratio_code}, 32'd0);
         check("R9 pad data", m_data, 32'hFFFF_FFFF);
         check("R9 pad handshake", {29'd0, m_valid, m_last, s_ready}, {29'd0, 3'b100});
         @(negedge clk);
      end
      pad_active = 1'b0;
      s_valid = 1'b0;
      s_last  = 1'b0;
      #1;
      check("R10 code restored", {30'd0, ratio_code}, 32'd3);
      check("R9 no word taken", {31'd0, ratio_valid}, 32'd1);
   endtask

   task automatic t_backpressure;
      @(negedge clk);
      m_ready = 1'b0;
      s_valid = 1'b1;
      s_data  = 32'hCAFE_0001;
      #1;
      check("R2 ready follows", {31'd0, s_ready}, 32'd0);
      check("R2 data passes", m_data, 32'hCAFE_0001);
      @(negedge clk);
      s_valid = 1'b0;
      m_ready = 1'b1;
      #1;
      check("R2 stalled word not taken", {31'd0, ratio_valid}, 32'd1);
   endtask

   task automatic finish_run;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      t_classify(2'b00, 1'b1, "plain");
      t_classify(2'b00, 1'b0, "compressed");
      t_classify(2'b01, 1'b1, "enc 01");
      t_classify(2'b10, 1'b1, "enc 10");
      t_classify(2'b11, 1'b0, "enc+cmp");
      t_long_stream();
      t_backpressure();
      t_short_stream();
      t_pad();
      finish_run();
   end

endmodule